// File: doc/BRIEF.md
# Move-Only Transfer Processor Core

This block is a 16-bit processor core whose only operation copies one word from one bus address to another. Each instruction takes two consecutive words in memory. The first word is the address to read from and the second is the address to write to. The core has no opcode decoder, no arithmetic unit and no register file. Arithmetic, comparison and branching come from peripherals that sit on the same bus and react to words being written to them or read from them.

One 16-bit bus carries both code and data. The core drives the address, a read strobe, a write strobe and the write data, and it takes read data back in the same cycle. Every instruction runs as four single-clock steps: fetch the source word, fetch the destination word, read the source, write the destination. The program counter sits at the top address of the map, so a jump is an ordinary move whose destination is that address. By convention code and constants live in the lower half of the map and RAM starts at 0x8000. The core itself does not enforce this layout.

Top module: `mv_move_core`

## Requirements
- R1: A synchronous active-high reset puts the core in the source-fetch step with program counter 0x0000. While reset is held, and in the first cycle after it is released, the bus shows address 0x0000 with the read strobe high and the write strobe low.
- R2: After reset the steps repeat in a fixed four-cycle order: source fetch, destination fetch, source read, destination write. The write strobe is high in exactly one cycle of every four and is never high in two cycles in a row.
- R3: In the source-fetch cycle the bus address is the program counter. In the destination-fetch cycle it is that value plus one. The words returned in these two cycles are taken as the source and destination addresses.
- R4: In the read cycle the bus address equals the word returned in the source-fetch cycle of the same instruction.
- R5: In the write cycle the bus address equals the word returned in the destination-fetch cycle. The write data equals the word returned in the read cycle.
- R6: The program counter goes up by one in each fetch cycle and holds its value in the read and write cycles. It wraps from 0xFFFF to 0x0000. When no jump occurs, each source fetch is at the previous destination-fetch address plus one.
- R7: A write to address 0xFFFF loads the program counter. The next source fetch uses exactly the written value, with no increment added. The write still appears on the bus.
- R8: Exactly one strobe is high in every cycle. The read strobe is high in both fetch cycles and in the read cycle. The write strobe is high only in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | output | 16 | Bus address for the current step |
| bus_rd | output | 1 | Read strobe: high in both fetch cycles and the read cycle |
| bus_wr | output | 1 | Write strobe: high in the write cycle |
| bus_wdata | output | 16 | Word being written in the write cycle |
| bus_rdata | input | 16 | Word returned by memory or a peripheral during a read cycle |

## Verification
The bound checker watches the step order, the strobes and the address relations on every cycle. It checks that a write comes only after three reads and that the destination fetch follows the source fetch by one address. It also checks that the read and write addresses match the fetched words, that the write data matches the word just read, and that the next fetch lands either one past the last fetch or on a value just written to the program counter. Some behaviour shows only at the program level, and only the bench scenarios can show it. These cover the reset state itself, a loop built on a memory-mapped adder that produces the correct running result, program counter wrap-around after a jump near the top of the map, and long random move streams whose jumps land on arbitrary addresses, each compared cycle by cycle with an independent bench model.

// File: rtl/mvcore_pkg.sv
package mvcore_pkg;
   typedef enum logic [1:0] {
      PH_FSRC  = 2'd0,
      PH_FDST  = 2'd1,
      PH_READ  = 2'd2,
      PH_WRITE = 2'd3
   } phase_t;
endpackage

// File: rtl/mv_phase_seq.sv
module mv_phase_seq import mvcore_pkg::*; #(
   parameter bit ONEHOT = 1'b0
) (
   input  logic   clk,
   input  logic   rst,
   output phase_t phase
);
   generate
      if (ONEHOT) begin : g_ring
         logic [3:0] ring;
         always_ff @(posedge clk) begin
            if (rst) ring <= 4'b0001;
            else     ring <= {ring[2:0], ring[3]};
         end
         always_comb begin
            unique case (ring)
               4'b0010: phase = PH_FDST;
               4'b0100: phase = PH_READ;
               4'b1000: phase = PH_WRITE;
               default: phase = PH_FSRC;
            endcase
         end
      end else begin : g_count
         logic [1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst) cnt <= 2'd0;
            else     cnt <= cnt + 2'd1;
         end
         assign phase = phase_t'(cnt);
      end
   endgenerate
endmodule

// File: rtl/mv_pc.sv
module mv_pc import mvcore_pkg::*; #(
   parameter int          W        = 16,
   parameter logic [W-1:0] PC_ADDR  = '1,
   parameter logic [W-1:0] RESET_PC = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  phase_t       phase,
   input  logic [W-1:0] dst,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] pc
);
   localparam logic [W-1:0] STEP = W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= RESET_PC;
      end else begin
         unique case (phase)
            PH_FSRC, PH_FDST: pc <= pc + STEP;
            PH_WRITE:         if (dst == PC_ADDR) pc <= wdata;
            default:          pc <= pc;
         endcase
      end
   end
endmodule

// File: rtl/mv_xfer_regs.sv
module mv_xfer_regs import mvcore_pkg::*; #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  phase_t       phase,
   input  logic [W-1:0] rdata,
   output logic [W-1:0] src,
   output logic [W-1:0] dst,
   output logic [W-1:0] dat
);
   always_ff @(posedge clk) begin
      if (rst) begin
         src <= '0;
         dst <= '0;
         dat <= '0;
      end else begin
         unique case (phase)
            PH_FSRC: src <= rdata;
            PH_FDST: dst <= rdata;
            PH_READ: dat <= rdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mv_move_core.sv
module mv_move_core import mvcore_pkg::*; #(
   parameter int           W            = 16,
   parameter logic [W-1:0] PC_ADDR      = '1,
   parameter logic [W-1:0] RESET_PC     = '0,
   parameter bit           ONEHOT_PHASE = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] bus_addr,
   output logic         bus_rd,
   output logic         bus_wr,
   output logic [W-1:0] bus_wdata,
   input  logic [W-1:0] bus_rdata
);
   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("mv_move_core: W must be between 2 and 32");
      end
   endgenerate

   phase_t         phase;
   logic [W-1:0]   pc;
   logic [W-1:0]   src_q;
   logic [W-1:0]   dst_q;
   logic [W-1:0]   dat_q;

   mv_phase_seq #(.ONEHOT(ONEHOT_PHASE)) u_seq (
      .clk   (clk),
      .rst   (rst),
      .phase (phase)
   );

   mv_pc #(.W(W), .PC_ADDR(PC_ADDR), .RESET_PC(RESET_PC)) u_pc (
      .clk   (clk),
      .rst   (rst),
      .phase (phase),
      .dst   (dst_q),
      .wdata (dat_q),
      .pc    (pc)
   );

   mv_xfer_regs #(.W(W)) u_regs (
      .clk   (clk),
      .rst   (rst),
      .phase (phase),
      .rdata (bus_rdata),
      .src   (src_q),
      .dst   (dst_q),
      .dat   (dat_q)
   );

   always_comb begin
      unique case (phase)
         PH_READ:  bus_addr = src_q;
         PH_WRITE: bus_addr = dst_q;
         default:  bus_addr = pc;
      endcase
   end

   assign bus_rd    = (phase != PH_WRITE);
   assign bus_wr    = (phase == PH_WRITE);
   assign bus_wdata = dat_q;
endmodule

// File: rtl/mv_move_core_chk.sv
module mv_move_core_chk #(
   parameter int           W       = 16,
   parameter logic [W-1:0] PC_ADDR = '1
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] bus_addr,
   input logic         bus_rd,
   input logic         bus_wr,
   input logic [W-1:0] bus_wdata,
   input logic [W-1:0] bus_rdata
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [1:0]   rd_run;
   logic [W-1:0] src_cap, dst_cap, dat_cap, fd_addr, jval;
   logic         fd_valid, jumped;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_run   <= 2'd0;
         src_cap  <= '0;
         dst_cap  <= '0;
         dat_cap  <= '0;
         fd_addr  <= '0;
         jval     <= '0;
         fd_valid <= 1'b0;
         jumped   <= 1'b0;
      end else begin
         if (bus_wr) begin
            rd_run <= 2'd0;
            jumped <= (bus_addr == PC_ADDR);
            jval   <= bus_wdata;
         end else if (bus_rd && rd_run != 2'd3) begin
            rd_run <= rd_run + 2'd1;
         end
         if (bus_rd && rd_run == 2'd0) src_cap <= bus_rdata;
         if (bus_rd && rd_run == 2'd1) begin
            dst_cap  <= bus_rdata;
            fd_addr  <= bus_addr;
            fd_valid <= 1'b1;
         end
         if (bus_rd && rd_run == 2'd2) dat_cap <= bus_rdata;
      end
   end

   // R8
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      bus_rd ^ bus_wr);

   // R2
   wr_after_three_chk: assert property (@(posedge clk) disable iff (rst)
      bus_wr |-> rd_run == 2'd3);

   // R2
   wr_single_chk: assert property (@(posedge clk) disable iff (rst)
      bus_wr |=> bus_rd);

   // R3
   fdst_next_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && rd_run == 2'd1) |-> bus_addr == $past(bus_addr) + ONE);

   // R4
   read_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && rd_run == 2'd2) |-> bus_addr == src_cap);

   // R5
   write_addr_chk: assert property (@(posedge clk) disable iff (rst)
      bus_wr |-> bus_addr == dst_cap);

   // R5
   write_data_chk: assert property (@(posedge clk) disable iff (rst)
      bus_wr |-> bus_wdata == dat_cap);

   // R6
   seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && rd_run == 2'd0 && fd_valid && !jumped) |-> bus_addr == fd_addr + ONE);

   // R7
   jump_target_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && rd_run == 2'd0 && fd_valid && jumped) |-> bus_addr == jval);
endmodule

bind mv_move_core mv_move_core_chk #(.W(W), .PC_ADDR(PC_ADDR)) u_chk (.*);

// File: tb/sim_mv_move_core.sv
module sim_mv_move_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] bus_addr, bus_wdata;
   logic [15:0] bus_rdata;
   logic        bus_rd, bus_wr;

   always #5 clk = ~clk;

   mv_move_core u0 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   // memory model: 256 words at 0x0000, 256 words at 0x8000; adder at 0xC000/1/2
   logic [15:0] mem [0:511];
   logic [15:0] alu_a = 16'h0, alu_b = 16'h0;
   logic        ld_en = 1'b0;
   logic [8:0]  ld_a = 9'h0;
   logic [15:0] ld_v = 16'h0;

   function automatic logic mapped(input logic [15:0] a);
      return a[14:8] == 7'h0;
   endfunction

   always_comb begin
      if (!bus_rd)                   bus_rdata = 16'h0;
      else if (bus_addr == 16'hC002) bus_rdata = alu_a + alu_b;
      else if (bus_addr[14:8] == 7'h0) bus_rdata = mem[{bus_addr[15], bus_addr[7:0]}];
      else                           bus_rdata = 16'h0;
   end

   always @(posedge clk) begin
      if (ld_en) mem[ld_a] <= ld_v;
      else if (!rst && bus_wr) begin
         if (bus_addr == 16'hC000)      alu_a <= bus_wdata;
         else if (bus_addr == 16'hC001) alu_b <= bus_wdata;
         else if (mapped(bus_addr))     mem[{bus_addr[15], bus_addr[7:0]}] <= bus_wdata;
      end
   end

   function automatic logic [15:0] mem_rd(input logic [15:0] a);
      if (a == 16'hC002) return alu_a + alu_b;
      if (mapped(a)) return mem[{a[15], a[7:0]}];
      return 16'h0;
   endfunction

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load(input logic [15:0] a, input logic [15:0] v);
      ld_en = 1'b1; ld_a = {a[15], a[7:0]}; ld_v = v;
      @(posedge clk); #1;
      ld_en = 1'b0;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 512; i++) load(i[8] ? (16'h8000 | 16'(i[7:0])) : 16'(i[7:0]), 16'h0);
   endtask

   // reference model state
   int          m_ph;
   logic [15:0] m_pc, m_src, m_dst, m_dat;
   bit          m_jumped, m_started;

   task automatic model_reset();
      m_ph = 0; m_pc = 16'h0; m_src = 0; m_dst = 0; m_dat = 0;
      m_jumped = 1'b0; m_started = 1'b0;
   endtask

   task automatic step();
      logic [15:0] ea;
      string tag;
      ea = (m_ph <= 1) ? m_pc : (m_ph == 2) ? m_src : m_dst;
      case (m_ph)
         0: tag = m_jumped ? "R7" : (m_started ? "R6" : "R3");
         1: tag = "R3";
         2: tag = "R4";
         default: tag = "R5";
      endcase
      chk(bus_addr === ea, tag, "address", bus_addr, ea);
      chk(bus_rd === (m_ph != 3), "R8", "read strobe", 16'(bus_rd), 16'(m_ph != 3));
      chk(bus_wr === (m_ph == 3), "R2", "write strobe", 16'(bus_wr), 16'(m_ph == 3));
      if (m_ph == 3) chk(bus_wdata === m_dat, "R5", "write data", bus_wdata, m_dat);
      case (m_ph)
         0: begin m_src = mem_rd(m_pc); m_pc = m_pc + 16'd1; m_started = 1'b1; end
         1: begin m_dst = mem_rd(m_pc); m_pc = m_pc + 16'd1; end
         2: m_dat = mem_rd(m_src);
         default: begin
            m_jumped = (m_dst == 16'hFFFF);
            if (m_jumped) m_pc = m_dat;
         end
      endcase
      m_ph = (m_ph + 1) % 4;
   endtask

   task automatic start();
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      // R1: state while reset is held
      chk(bus_addr === 16'h0 && bus_rd === 1'b1 && bus_wr === 1'b0, "R1",
          "reset state", bus_addr, 16'h0);
      rst = 1'b0;
      model_reset();
   endtask

   task automatic run(input int ncyc);
      for (int i = 0; i < ncyc; i++) begin
         step();
         @(negedge clk);
      end
   endtask

   function automatic logic [15:0] fib(input int loops);
      logic [15:0] a = 0, b = 1, t;
      for (int i = 0; i < loops; i++) begin t = a + b; a = b; b = t; end
      return b;
   endfunction

   function automatic logic [15:0] gen_addr();
      int r = int'($urandom % 16);
      if (r < 6)  return 16'($urandom % 256);
      if (r < 11) return 16'h8000 | 16'($urandom % 256);
      if (r == 11) return 16'hC000;
      if (r == 12) return 16'hC001;
      if (r == 13) return 16'hC002;
      if (r == 14) return 16'hFFFF;
      return 16'($urandom);
   endfunction

   initial begin
      void'($urandom(32'd24681));
      // scenario 1: adder loop, jump back each iteration (R6, R7)
      clear_mem();
      load(16'h40, 16'h0000); load(16'h41, 16'h0001); load(16'h42, 16'h0004);
      load(16'h00, 16'h0040); load(16'h01, 16'h8000);
      load(16'h02, 16'h0041); load(16'h03, 16'h8001);
      load(16'h04, 16'h8000); load(16'h05, 16'hC000);
      load(16'h06, 16'h8001); load(16'h07, 16'hC001);
      load(16'h08, 16'h8001); load(16'h09, 16'h8000);
      load(16'h0A, 16'hC002); load(16'h0B, 16'h8001);
      load(16'h0C, 16'h0042); load(16'h0D, 16'hFFFF);
      start();
      run(8 + 20 * 10);
      chk(mem[9'h101] === fib(10), "R5", "loop result", mem[9'h101], fib(10));

      // scenario 2: jump near the top of the map, program counter wraps (R6, R7)
      clear_mem();
      load(16'h43, 16'hFFFE);
      load(16'h00, 16'h0043); load(16'h01, 16'hFFFF);
      start();
      run(40);

      // scenario 3: random move streams with random jumps, then a mid-run reset (R1)
      clear_mem();
      for (int i = 0; i < 256; i++) load(16'(i), gen_addr());
      for (int i = 0; i < 256; i++) load(16'h8000 | 16'(i), 16'($urandom));
      start();
      run(3000);
      rst = 1'b1;
      @(negedge clk);
      chk(bus_addr === 16'h0 && bus_rd === 1'b1 && bus_wr === 1'b0, "R1",
          "mid-run reset", bus_addr, 16'h0);
      rst = 1'b0;
      model_reset();
      run(1000);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule